// File: doc/BRIEF.md
# Frame-aligned audio sample FIFO

This block sits between a bus-mastering fetch engine and an audio packetizer and buffers interleaved multichannel PCM samples. While the arm input is low the block is idle and empty. Raising arm latches the channel count and opens the write side, and `fetch_req` tells the fetch engine that a whole frame of room is free. The fetch engine delivers samples one at a time over a valid/ready stream.

The read side is also a valid/ready stream and gives one sample per handshake, in channel order. Each sample comes with its channel index and a last-of-frame marker. Nothing is offered until the FIFO holds at least one full frame, so a read made while the first frame is still arriving can never return a stale or repeated sample. If the FIFO lacks a full frame at a frame boundary after that point, the block sends a frame of zero samples instead and sets a sticky underflow flag. Stored data is left untouched, so channel alignment is kept. Dropping arm flushes everything and returns the block to idle.

Back-pressure rules: a sample is written when `in_valid` and `in_ready` are both high at a clock edge. A sample is consumed when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data`, `out_chan` and `out_last` hold their values. Once the packetizer has started on a frame, every remaining sample of that frame is available without gaps.

Top module: `afs_frame_fifo`

## Requirements
- R1: While arm is low (and after reset) `in_ready`, `fetch_req`, `out_valid` and `underflow` are all low, and no sample is accepted.
- R2: After arm rises, `out_valid` stays low until the FIFO holds at least as many samples as the configured channel count.
- R3: Stored samples leave in write order. `out_chan` counts 0 to N-1 within each frame, and `out_last` is high only on channel N-1.
- R4: While `out_valid` is high and `out_ready` is low, `out_data` and `out_chan` do not change.
- R5: If fewer than N samples are stored when a frame ends, the next frame is N samples of value 0 with channel indices 0 to N-1. No stored sample is consumed by it, and `underflow` goes high and stays high until arm drops.
- R6: After a zero frame, the next real frame starts at channel 0 with the oldest stored sample, with no sample lost or repeated.
- R7: `in_ready` is low when DEPTH samples are stored, and samples offered in that state are not stored.
- R8: While armed, `fetch_req` is high exactly when free space (DEPTH minus stored samples) is at least N.
- R9: Dropping arm discards all stored samples and clears `underflow` and the channel index. A later arming applies the R2 gating again, and only newly written samples are read.
- R10: N is sampled from `chan_cnt` when arm rises and stays fixed while armed. A value of 0 is used as 1, and a value above MAX_CH is used as MAX_CH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Software start level; low flushes and idles the block |
| chan_cnt | input | $clog2(MAX_CH+1) | Configured channels per frame |
| fetch_req | output | 1 | Room for at least one full frame is free |
| in_valid | input | 1 | Write-side sample valid |
| in_ready | output | 1 | Write-side ready |
| in_data | input | DW | Write-side sample |
| out_valid | output | 1 | Read-side sample valid |
| out_ready | input | 1 | Read-side ready |
| out_data | output | DW | Read-side sample (0 during a zero frame) |
| out_chan | output | max(1,$clog2(MAX_CH)) | Channel index of the offered sample |
| out_last | output | 1 | Offered sample is the last channel of its frame |
| underflow | output | 1 | Sticky: a zero frame has been sent since arming |

## Verification
The hardest condition to reach from the ports is the frame boundary where stored data runs out. It has to be combined with data arriving in the middle of a zero frame, because that is where a flawed design would pull real samples into the padding and rotate the channels. The bench drains exactly two full frames and takes all but the last zero sample. It then writes a new frame while holding `out_ready` low, and only after that completes the zero frame. The following frame must start on channel 0 with the first new sample. This sequence runs for every channel count from 1 to MAX_CH on a small configuration.

// File: rtl/afs_pkg.sv
`timescale 1ns/1ps
package afs_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FILL = 2'd1,
    SEQ_RUN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/afs_store.sv
`timescale 1ns/1ps
module afs_store #(
  parameter int DW    = 24,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign rdata = mem[rp];
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/afs_seq.sv
`timescale 1ns/1ps
module afs_seq
  import afs_pkg::*;
#(
  parameter int MAX_CH = 8,
  parameter int DEPTH  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     arm,
  input  logic [$clog2(MAX_CH+1)-1:0]              chan_cnt,
  input  logic [$clog2(DEPTH+1)-1:0]               count,
  input  logic                                     full,
  input  logic                                     in_valid,
  input  logic                                     out_ready,
  output logic                                     flush,
  output logic                                     push,
  output logic                                     pop,
  output logic                                     in_ready,
  output logic                                     fetch_req,
  output logic                                     out_valid,
  output logic                                     out_zero,
  output logic [((MAX_CH>1)?$clog2(MAX_CH):1)-1:0] out_chan,
  output logic                                     out_last,
  output logic                                     underflow
);
  localparam int CH_W = $clog2(MAX_CH + 1);
  localparam int IX_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int KW   = ((CW > CH_W) ? CW : CH_W) + 1;

  seq_state_t      st;
  logic [CH_W-1:0] cfg_ch, cfg_in;
  logic [IX_W-1:0] idx;
  logic            zero_q, uf_q;
  logic [KW-1:0]   cnt_k, cfg_k, idx_k, nxt_k, free_k;
  logic            hs, at_last, short_next;

  always_comb begin
    if (chan_cnt == '0)                  cfg_in = CH_W'(1);
    else if (chan_cnt > CH_W'(MAX_CH))   cfg_in = CH_W'(MAX_CH);
    else                                 cfg_in = chan_cnt;
  end

  assign flush      = !arm;
  assign in_ready   = (st != SEQ_IDLE) && !full;
  assign push       = in_valid && in_ready;
  assign out_valid  = (st == SEQ_RUN);
  assign hs         = out_valid && out_ready;
  assign pop        = hs && !zero_q;

  assign cnt_k      = KW'(count);
  assign cfg_k      = KW'(cfg_ch);
  assign idx_k      = KW'(idx);
  assign nxt_k      = cnt_k + KW'(push) - KW'(pop);
  assign free_k     = KW'(DEPTH) - cnt_k;
  assign at_last    = (idx_k == cfg_k - KW'(1));
  assign short_next = (nxt_k < cfg_k);

  assign fetch_req  = (st != SEQ_IDLE) && (free_k >= cfg_k);
  assign out_zero   = zero_q;
  assign out_chan   = idx;
  assign out_last   = out_valid && at_last;
  assign underflow  = uf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SEQ_IDLE;
      cfg_ch <= CH_W'(1);
      idx    <= '0;
      zero_q <= 1'b0;
      uf_q   <= 1'b0;
    end else if (!arm) begin
      st     <= SEQ_IDLE;
      idx    <= '0;
      zero_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      unique case (st)
        SEQ_IDLE: begin
          st     <= SEQ_FILL;
          cfg_ch <= cfg_in;
        end
        SEQ_FILL: begin
          idx    <= '0;
          zero_q <= 1'b0;
          if (cnt_k >= cfg_k) st <= SEQ_RUN;
        end
        SEQ_RUN: begin
          if (hs) begin
            if (at_last) begin
              idx    <= '0;
              zero_q <= short_next;
              if (short_next) uf_q <= 1'b1;
            end else begin
              idx <= idx + IX_W'(1);
            end
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/afs_frame_fifo.sv
`timescale 1ns/1ps
module afs_frame_fifo #(
  parameter int DW     = 24,
  parameter int MAX_CH = 8,
  parameter int DEPTH  = 16
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     arm,
  input  logic [$clog2(MAX_CH+1)-1:0]              chan_cnt,
  output logic                                     fetch_req,
  input  logic                                     in_valid,
  output logic                                     in_ready,
  input  logic [DW-1:0]                            in_data,
  output logic                                     out_valid,
  input  logic                                     out_ready,
  output logic [DW-1:0]                            out_data,
  output logic [((MAX_CH>1)?$clog2(MAX_CH):1)-1:0] out_chan,
  output logic                                     out_last,
  output logic                                     underflow
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          flush, push, pop, full, out_zero;
  logic [CW-1:0] count;
  logic [DW-1:0] rdata;

  afs_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (push),
    .wdata (in_data),
    .pop   (pop),
    .rdata (rdata),
    .count (count),
    .full  (full)
  );

  afs_seq #(.MAX_CH(MAX_CH), .DEPTH(DEPTH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .chan_cnt  (chan_cnt),
    .count     (count),
    .full      (full),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .flush     (flush),
    .push      (push),
    .pop       (pop),
    .in_ready  (in_ready),
    .fetch_req (fetch_req),
    .out_valid (out_valid),
    .out_zero  (out_zero),
    .out_chan  (out_chan),
    .out_last  (out_last),
    .underflow (underflow)
  );

  assign out_data = out_zero ? '0 : rdata;
endmodule

// File: rtl/afs_frame_fifo_chk.sv
`timescale 1ns/1ps
module afs_frame_fifo_chk #(
  parameter int DW     = 24,
  parameter int MAX_CH = 8,
  parameter int DEPTH  = 16
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     arm,
  input logic                                     in_ready,
  input logic                                     full,
  input logic                                     pop,
  input logic [$clog2(DEPTH+1)-1:0]               count,
  input logic                                     out_valid,
  input logic                                     out_ready,
  input logic [DW-1:0]                            out_data,
  input logic [((MAX_CH>1)?$clog2(MAX_CH):1)-1:0] out_chan,
  input logic                                     out_last,
  input logic                                     underflow
);
  localparam int IX_W = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;

  a_r1_idle_when_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (!out_valid && !in_ready && !underflow));

  a_r3_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  a_r3_chan_steps: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (out_valid && out_ready && !out_last) |=> (out_valid && out_chan == $past(out_chan) + IX_W'(1)));

  a_r3_frame_restarts: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (out_valid && out_ready && out_last) |=> (out_chan == '0));

  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || !arm)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

  a_r5_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && arm) |=> underflow);

  a_r7_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
endmodule

bind afs_frame_fifo afs_frame_fifo_chk #(.DW(DW), .MAX_CH(MAX_CH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .in_ready  (in_ready),
  .full      (full),
  .pop       (pop),
  .count     (count),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_chan  (out_chan),
  .out_last  (out_last),
  .underflow (underflow)
);

// File: tb/afs_frame_fifo_test.sv
`timescale 1ns/1ps
module afs_frame_fifo_test;
  localparam int DW = 8, MAX_CH = 4, DEPTH = 8;

  logic clk = 0, rst_n = 0, arm = 0;
  logic [2:0] chan_cnt = 3'd1;
  logic in_valid = 0, out_ready = 0;
  logic [DW-1:0] in_data = '0;
  logic fetch_req, in_ready, out_valid, out_last, underflow;
  logic [DW-1:0] out_data;
  logic [1:0] out_chan;
  int checks = 0, errs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  afs_frame_fifo #(.DW(DW), .MAX_CH(MAX_CH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .chan_cnt(chan_cnt), .fetch_req(fetch_req),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_chan(out_chan), .out_last(out_last), .underflow(underflow));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input logic [DW-1:0] v);
    in_valid = 1; in_data = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pull(input string req, input int d, input int ch, input int last);
    logic [DW-1:0] d0;
    logic [1:0] c0;
    while (!out_valid) @(negedge clk);
    d0 = out_data; c0 = out_chan;
    check({req, " data"}, out_data, d);
    check({req, " chan"}, out_chan, ch);
    check({req, " last"}, out_last, last);
    @(negedge clk);
    check("R4 data held", out_data, d0);
    check("R4 chan held", out_chan, c0);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic start(input int c);
    chan_cnt = 3'(c); arm = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic stop();
    arm = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset in_ready", in_ready, 0);
    check("R1 reset fetch_req", fetch_req, 0);
    check("R1 reset underflow", underflow, 0);
    in_valid = 1; in_data = 8'h55;
    repeat (3) @(negedge clk);
    in_valid = 0;
    check("R1 disarmed ignores writes", out_valid, 0);

    // sweep over every channel count
    for (int c = 1; c <= MAX_CH; c++) begin
      int b1 = c * 16, b2 = c * 16 + 8;
      start(c);
      check("R8 fetch_req armed", fetch_req, 1);
      check("R2 empty gated", out_valid, 0);
      for (int i = 0; i < c - 1; i++) push(8'(b1 + i));
      repeat (3) @(negedge clk);
      check("R2 partial frame gated", out_valid, 0);
      for (int i = c - 1; i < 2 * c; i++) push(8'(b1 + i));
      for (int k = 0; k < 2 * c; k++) pull("R3", b1 + k, k % c, (k % c == c - 1) ? 1 : 0);
      check("R5 underflow raised", underflow, 1);
      for (int j = 0; j < c - 1; j++) pull("R5 zero frame", 0, j, 0);
      for (int i = 0; i < c; i++) push(8'(b2 + i));
      pull("R5 zero frame end", 0, c - 1, 1);
      for (int k = 0; k < c; k++) pull("R6 realigned", b2 + k, k, (k == c - 1) ? 1 : 0);
      check("R5 underflow sticky", underflow, 1);
      stop();
      check("R9 flush out_valid", out_valid, 0);
      check("R9 flush underflow", underflow, 0);
      check("R1 disarm in_ready", in_ready, 0);
      check("R1 disarm fetch_req", fetch_req, 0);
    end

    // flush discards old data and re-gates
    start(2);
    push(8'hA0); push(8'hA1); push(8'hA2);
    stop();
    start(2);
    push(8'hB0);
    repeat (3) @(negedge clk);
    check("R9 rearm gated", out_valid, 0);
    push(8'hB1);
    pull("R9 new data only", 8'hB0, 0, 0);
    pull("R9 new data only", 8'hB1, 1, 1);
    stop();

    // full FIFO and fetch request threshold
    start(4);
    for (int i = 0; i < 4; i++) push(8'(8'hC0 + i));
    check("R8 free equals N", fetch_req, 1);
    push(8'hC4);
    check("R8 free below N", fetch_req, 0);
    for (int i = 5; i < DEPTH; i++) push(8'(8'hC0 + i));
    check("R7 full in_ready", in_ready, 0);
    in_valid = 1; in_data = 8'hEE;
    repeat (3) @(negedge clk);
    in_valid = 0;
    for (int k = 0; k < DEPTH; k++) pull("R7 stored", 8'hC0 + k, k % 4, (k % 4 == 3) ? 1 : 0);
    pull("R7 nothing extra", 0, 0, 0);
    stop();

    // channel count clamping and latching
    start(0);
    push(8'hD0); push(8'hD1);
    pull("R10 zero as one", 8'hD0, 0, 1);
    pull("R10 zero as one", 8'hD1, 0, 1);
    stop();
    start(7);
    chan_cnt = 3'd1;
    for (int i = 0; i < 3; i++) push(8'(8'hE0 + i));
    repeat (3) @(negedge clk);
    check("R10 clamp and latch gated", out_valid, 0);
    push(8'hE3);
    for (int k = 0; k < 4; k++) pull("R10 clamp to max", 8'hE0 + k, k, (k == 3) ? 1 : 0);
    stop();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
    end
  end
endmodule